// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a watchdog timer placed on a simple 32-bit register bus. It counts enable pulses from a slow tick source, normally 32 kHz, and shares the bus clock with that source. Software sets an interval and starts the timer. It must then keep restarting the count before the count runs out. If the count runs out, the block drives a reset pulse of fixed length. Software can also request the same pulse at once through a dedicated register.

Each register checks its write. A write to the control or interval register is taken only if a key is present in a fixed part of the data word. A write to the restart or immediate-reset register is taken only if the data word matches one exact 32-bit value. Any write that fails its check changes nothing.

The reset pulse appears on three outputs. One is an internal reset line. One is an external pin with selectable polarity. The last is an interrupt line that is gated by an enable bit. The auto-start and dual-mode settings are stored and read back, and have no other effect.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control register reads 0, the interval register reads 1984 in bits [15:5] (31 s at 64 units per second), `wdt_rst_o` and `irq_o` are low, and `ext_rst_o` is high.
- R2: A write to offset 0x00 is taken only when data bits [31:24] equal 0x22. Bit 0 is enable, bit 1 is external polarity (1 = active high), bit 2 is external output enable, bit 3 is interrupt enable, bit 4 is auto start and bit 6 is dual mode. Reads return these bits, with bit 5 and bits [31:7] as zero.
- R3: A write to offset 0x04 is taken only when data bits [4:0] equal 0x08. The interval in units sits in bits [15:5]. Reads return the interval there and zero in every other bit.
- R4: A write of exactly 0x00001971 to offset 0x08 reloads the count with interval × TICK_PER_UNIT ticks. Any other value or offset does not reload.
- R5: While enabled, the pulse starts on the tick that completes interval × TICK_PER_UNIT ticks after the last reload. Cycles without `tick_en` do not advance the count.
- R6: While disabled, the count is frozen and no expiry occurs. A control write that changes enable from 0 to 1 reloads the count. A control write that keeps enable at 1 does not reload.
- R7: A write of exactly 0x00001209 to offset 0x14 starts the pulse whether or not the timer is enabled. Other values do nothing.
- R8: `wdt_rst_o` is high for exactly PULSE_CYC cycles, starting the cycle after the triggering edge. A trigger that arrives while a pulse is active is dropped. After an expiry the count reloads and keeps running.
- R9: When the external output is enabled, `ext_rst_o` carries the pulse at the selected polarity. When it is not enabled, `ext_rst_o` holds the inactive level of the selected polarity.
- R10: `irq_o` equals the pulse while the interrupt enable bit is set, and is low otherwise.
- R11: An interval of 0 expires on the first tick after a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle tick strobe from the slow time base |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, including key or magic value |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | Internal reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin at the programmed polarity |
| irq_o | output | 1 | Interrupt line, gated pulse |

## Verification
A key check that is wrong either lets a bad write through or blocks a good one. Either way, the register read-back differs on the next read. A restart or enable edge that wrongly reloads, or fails to reload, moves the expiry by a known number of ticks, and the difference shows as soon as the pulse rises. An error in the pulse counter changes the high time of `wdt_rst_o` within a few cycles. With a zero interval, the fixed high-high-high-low pattern exposes any error in the rule that drops triggers during a pulse.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int LEN_LSB = 5;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LEN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_KICK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SWRST = 8'h14;

    localparam logic [7:0]         MODE_KEY    = 8'h22;
    localparam logic [LEN_LSB-1:0] LEN_KEY     = 5'h08;
    localparam logic [BUS_W-1:0]   KICK_MAGIC  = 32'h0000_1971;
    localparam logic [BUS_W-1:0]   SWRST_MAGIC = 32'h0000_1209;

    typedef struct packed {
        logic dual;
        logic autostart;
        logic irq_en;
        logic ext_en;
        logic ext_pol;
        logic en;
    } mode_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MODE,
        ACC_LEN,
        ACC_KICK,
        ACC_SWRST
    } acc_e;

    function automatic acc_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MODE:  return ACC_MODE;
            OFS_LEN:   return ACC_LEN;
            OFS_KICK:  return ACC_KICK;
            OFS_SWRST: return ACC_SWRST;
            default:   return ACC_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] mode_to_word(input mode_t m);
        return {25'd0, m.dual, 1'b0, m.autostart, m.irq_en, m.ext_en, m.ext_pol, m.en};
    endfunction

    function automatic mode_t word_to_mode(input logic [BUS_W-1:0] w);
        mode_t m;
        m.en        = w[0];
        m.ext_pol   = w[1];
        m.ext_en    = w[2];
        m.irq_en    = w[3];
        m.autostart = w[4];
        m.dual      = w[6];
        return m;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int DEF_LEN = 1984
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output mode_t             mode_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              reload,
    output logic              swrst,
    output logic [BUS_W-1:0]  rdata
);

    localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(DEF_LEN);

    acc_e  acc;
    mode_t mode_new;
    logic  mode_ok;
    logic  len_ok;
    logic  kick_ok;

    assign acc      = decode_addr(bus_addr);
    assign mode_new = word_to_mode(bus_wdata);

    assign mode_ok = bus_wr && (acc == ACC_MODE) && (bus_wdata[31:24] == MODE_KEY);
    assign len_ok  = bus_wr && (acc == ACC_LEN)  && (bus_wdata[LEN_LSB-1:0] == LEN_KEY);
    assign kick_ok = bus_wr && (acc == ACC_KICK)  && (bus_wdata == KICK_MAGIC);
    assign swrst   = bus_wr && (acc == ACC_SWRST) && (bus_wdata == SWRST_MAGIC);

    // reload on a correct restart word or on an enable rising edge
    assign reload = kick_ok || (mode_ok && mode_new.en && !mode_q.en);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            len_q  <= LEN_RST;
        end else begin
            if (mode_ok) mode_q <= mode_new;
            if (len_ok)  len_q  <= bus_wdata[LEN_LSB +: LEN_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (acc)
            ACC_MODE: rdata = mode_to_word(mode_q);
            ACC_LEN:  rdata[LEN_LSB +: LEN_W] = len_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
    parameter int LEN_W         = 11,
    parameter int TICK_PER_UNIT = 512,
    parameter int CNT_W         = LEN_W + $clog2(TICK_PER_UNIT) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             reload,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_q
);

    logic [CNT_W-1:0] load_val;
    logic             last;

    assign load_val = CNT_W'(len) * CNT_W'(TICK_PER_UNIT);
    assign last     = (cnt_q <= CNT_W'(1));
    assign expire   = en && tick && !reload && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (en && tick) begin
            cnt_q <= last ? load_val : cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int PULSE_CYC = 16,
    parameter int PW        = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);

    logic [PW-1:0] left_q;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (active) begin
            left_q <= left_q - PW'(1);
        end else if (trig) begin
            left_q <= PW'(PULSE_CYC);
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int TICK_PER_UNIT = 512,
    parameter int LEN_W         = 11,
    parameter int DEF_SECS      = 31,
    parameter int UNITS_PER_SEC = 64,
    parameter int PULSE_CYC     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_o,
    output logic        ext_rst_o,
    output logic        irq_o
);

    localparam int DEF_LEN = DEF_SECS * UNITS_PER_SEC;
    localparam int CNT_W   = LEN_W + $clog2(TICK_PER_UNIT) + 1;

    mode_t            mode_q;
    logic [LEN_W-1:0] len_q;
    logic             reload;
    logic             swrst;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse;

    kwdt_regs #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mode_q    (mode_q),
        .len_q     (len_q),
        .reload    (reload),
        .swrst     (swrst),
        .rdata     (bus_rdata)
    );

    kwdt_count #(.LEN_W(LEN_W), .TICK_PER_UNIT(TICK_PER_UNIT), .CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_q.en),
        .reload (reload),
        .tick   (tick_en),
        .len    (len_q),
        .expire (expire),
        .cnt_q  (cnt_q)
    );

    kwdt_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (expire || swrst),
        .active (pulse)
    );

    assign wdt_rst_o = pulse;
    assign irq_o     = pulse && mode_q.irq_en;
    assign ext_rst_o = mode_q.ext_en ? (mode_q.ext_pol ? pulse : !pulse) : !mode_q.ext_pol;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 14,
    parameter int PULSE_CYC = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [7:0]       mode_tag,
    input logic [4:0]       len_tag,
    input mode_t            mode_q,
    input logic [LEN_W-1:0] len_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             reload,
    input logic             wdt_rst_o,
    input logic             ext_rst_o,
    input logic             irq_o
);

    localparam int HW = $clog2(PULSE_CYC + 2) + 1;
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)            hi_run <= '0;
        else if (wdt_rst_o) hi_run <= hi_run + HW'(1);
        else                hi_run <= '0;
    end

    assert_mode_keyed_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MODE && mode_tag != MODE_KEY) |=> $stable(mode_q));

    assert_len_keyed_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LEN && len_tag != LEN_KEY) |=> $stable(len_q));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.en && !reload) |=> $stable(cnt_q));

    assert_ext_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_q.ext_en |-> (ext_rst_o == !mode_q.ext_pol));

    assert_pulse_short_R8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> (hi_run < HW'(PULSE_CYC)));

    assert_pulse_full_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_o) |-> (hi_run == HW'(PULSE_CYC)));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (wdt_rst_o && mode_q.irq_en));

endmodule

bind kwdt_top kwdt_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_kwdt_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .mode_tag  (bus_wdata[31:24]),
    .len_tag   (bus_wdata[4:0]),
    .mode_q    (mode_q),
    .len_q     (len_q),
    .cnt_q     (cnt_q),
    .reload    (reload),
    .wdt_rst_o (wdt_rst_o),
    .ext_rst_o (ext_rst_o),
    .irq_o     (irq_o)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

    localparam int TPU   = 4;
    localparam int PULSE = 3;
    localparam int DEFL  = 1984;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o, ext_rst_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;

    kwdt_top #(.TICK_PER_UNIT(TPU), .PULSE_CYC(PULSE)) i_kwdt_top (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .ext_rst_o(ext_rst_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(input int n, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (wdt_rst_o) seen = 1'b1;
        end
    endtask

    task automatic measure(input int maxn, input int per, output int n);
        n = 0;
        while (!wdt_rst_o && n < maxn) begin
            for (int i = 1; i < per; i++) begin
                tick_en = 1'b0;
                @(negedge clk);
            end
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            n++;
        end
        if (!wdt_rst_o) n = -1;
    endtask

    task automatic settle();
        tick_en = 1'b0;
        repeat (PULSE + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        seen;
        int          n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 mode", v, 32'h0);
        rd(8'h04, v); chk("R1 len", v, DEFL << 5);
        chk("R1 wdt_rst_o", {31'd0, wdt_rst_o}, 32'd0);
        chk("R1 ext_rst_o", {31'd0, ext_rst_o}, 32'd1);
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);

        // R2 sweep of the key byte
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h22) begin
                wr(8'h00, {b[7:0], 24'h0000FE});
                rd(8'h00, v); chk("R2 bad key ignored", v, 32'h0);
            end
        end
        wr(8'h00, 32'h2200_00FE);
        rd(8'h00, v); chk("R2 keyed write readback", v, 32'h0000_005E);
        wr(8'h00, 32'h2200_0000);
        rd(8'h00, v); chk("R2 cleared", v, 32'h0);

        // R3 sweep of the key field
        for (int k = 0; k < 32; k++) begin
            if (k != 8) begin
                wr(8'h04, (32'd5 << 5) | k);
                rd(8'h04, v); chk("R3 bad key ignored", v, DEFL << 5);
            end
        end
        wr(8'h04, (32'd5 << 5) | 32'h8);
        rd(8'h04, v); chk("R3 keyed write", v, 32'd5 << 5);
        wr(8'h04, 32'hFFFF_0000 | (32'd7 << 5) | 32'h8);
        rd(8'h04, v); chk("R3 upper bits dropped", v, 32'd7 << 5);

        // R5 interval sweep at two tick rates
        for (int per = 1; per <= 3; per += 2) begin
            for (int l = 1; l <= 8; l++) begin
                wr(8'h04, (l << 5) | 8);
                wr(8'h00, 32'h2200_0001);
                measure(200, per, n);
                chk("R5 expiry ticks", n, l * TPU);
                wr(8'h00, 32'h2200_0000);
                settle();
            end
        end

        // R8 reload after expiry
        wr(8'h04, (32'd3 << 5) | 8);
        wr(8'h00, 32'h2200_0001);
        measure(200, 1, n);
        chk("R8 first expiry", n, 3 * TPU);
        settle();
        measure(200, 1, n);
        chk("R8 second expiry after reload", n, 3 * TPU);
        wr(8'h00, 32'h2200_0000);
        settle();

        // R11 zero interval and R8 dropped triggers
        wr(8'h04, 32'h8);
        wr(8'h00, 32'h2200_0001);
        measure(10, 1, n);
        chk("R11 zero interval", n, 1);
        n = 0;
        for (int i = 0; i < 16; i++) begin
            if (wdt_rst_o) n++;
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
        chk("R8 retrigger pattern high count", n, 12);
        wr(8'h00, 32'h2200_0000);
        settle();

        // R4 restart magic
        wr(8'h04, (32'd4 << 5) | 8);
        wr(8'h00, 32'h2200_0001);
        run_ticks(10, seen);
        wr(8'h08, 32'h0000_1970);
        wr(8'h08, 32'h0001_1971);
        wr(8'h0C, 32'h0000_1971);
        measure(200, 1, n);
        chk("R4 wrong restart ignored", n, 6);
        wr(8'h00, 32'h2200_0000);
        settle();
        wr(8'h00, 32'h2200_0001);
        run_ticks(10, seen);
        wr(8'h08, 32'h0000_1971);
        measure(200, 1, n);
        chk("R4 restart reloads", n, 16);
        wr(8'h00, 32'h2200_0000);
        settle();

        // R6 freeze and enable edge
        wr(8'h04, (32'd2 << 5) | 8);
        wr(8'h00, 32'h2200_0001);
        run_ticks(5, seen);
        wr(8'h00, 32'h2200_0000);
        run_ticks(20, seen);
        chk("R6 no expiry while disabled", {31'd0, seen}, 32'd0);
        wr(8'h00, 32'h2200_0001);
        measure(200, 1, n);
        chk("R6 enable edge reloads", n, 8);
        wr(8'h00, 32'h2200_0000);
        settle();
        wr(8'h04, (32'd4 << 5) | 8);
        wr(8'h00, 32'h2200_0001);
        run_ticks(10, seen);
        wr(8'h00, 32'h2200_0009);
        measure(200, 1, n);
        chk("R6 enable kept high no reload", n, 6);
        wr(8'h00, 32'h2200_0000);
        settle();

        // R7 software reset and R8 width
        wr(8'h14, 32'h0000_1208);
        chk("R7 wrong value no pulse", {31'd0, wdt_rst_o}, 32'd0);
        wr(8'h14, 32'h0000_1209);
        chk("R7 pulse while disabled", {31'd0, wdt_rst_o}, 32'd1);
        n = 0;
        while (wdt_rst_o && n < 20) begin n++; @(negedge clk); end
        chk("R8 pulse width", n, PULSE);

        // R9 external pin
        wr(8'h00, 32'h2200_0006);
        chk("R9 high-active idle", {31'd0, ext_rst_o}, 32'd0);
        wr(8'h14, 32'h0000_1209);
        chk("R9 high-active pulse", {31'd0, ext_rst_o}, 32'd1);
        settle();
        wr(8'h00, 32'h2200_0004);
        chk("R9 low-active idle", {31'd0, ext_rst_o}, 32'd1);
        wr(8'h14, 32'h0000_1209);
        chk("R9 low-active pulse", {31'd0, ext_rst_o}, 32'd0);
        settle();
        wr(8'h00, 32'h2200_0002);
        wr(8'h14, 32'h0000_1209);
        chk("R9 pin off rst seen", {31'd0, wdt_rst_o}, 32'd1);
        chk("R9 pin off stays inactive", {31'd0, ext_rst_o}, 32'd0);
        settle();

        // R10 interrupt gating
        wr(8'h00, 32'h2200_0008);
        wr(8'h14, 32'h0000_1209);
        chk("R10 irq follows pulse", {31'd0, irq_o}, 32'd1);
        settle();
        wr(8'h00, 32'h2200_0000);
        wr(8'h14, 32'h0000_1209);
        chk("R10 irq masked", {31'd0, irq_o}, 32'd0);
        settle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule